// File: doc/BRIEF.md
# Multi-channel thermal sampling controller

This block is the digital side of a small array of on-die temperature sensors. Software programs it through a simple word-addressed register bus. It sets which channels are live, the acquisition windows handed to the analog front end, a sampling period and an optional averaging filter. A period timer then wakes the block. On each wake-up it asks the shared converter for one 12-bit sample from every live channel, lowest index first, using a request/valid handshake.

Samples either pass straight through or are summed per channel over a power-of-two group and divided by shifting. Each finished result lands in that channel's data register and raises a data-ready flag. Software clears a flag by writing a one to it. Per-channel enable bits decide which flags reach the single interrupt line. The calibration word is plain read/write storage, and turning readings into temperatures is left to software.

The period is counted in units of 2^TICK_W clocks, which is 4096 by default. One result per channel therefore appears every (P+1) * 2^TICK_W * 2^(T+1) clocks with the filter on, and every (P+1) * 2^TICK_W clocks with it off.

Top module: `thm_sample_ctrl`

## Requirements
- R1: After reset, every register reads 0 except calibration (byte offset 0x74), which reads 0x08000800. `irq` and `sns_req` are low, and each channel data register (0x80 + 4*n) reads 0 until its first result is stored.
- R2: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and only implemented bits read back. These are 0x00 bits [15:0] (acquisition time 0), 0x40 bits [3:0] (channel enables) and [31:16] (acquisition time 1), 0x44 bits [11:8] (interrupt enables) and [31:12] (period P), 0x70 bits [2:0] (bit 2 filter on, bits [1:0] type T), and all 32 bits of 0x74. Unmapped offsets read 0.
- R3: A channel whose enable bit (0x40 bit n) is clear is never requested, and with no channel enabled `sns_req` stays low.
- R4: Each period expiry requests every enabled channel exactly once, in ascending index order. `sns_req` and `sns_chan` hold until `sns_valid` is seen.
- R5: With the filter off, every accepted sample is stored unchanged in channel n's data register and sets status bit 8+n (offset 0x48).
- R6: With the filter on, the data register receives the floor of the mean of 2^(T+1) consecutive samples of that channel. Grouping restarts at every write of the filter register.
- R7: Consecutive results of a channel are spaced (P+1) * 2^TICK_W clocks apart with the filter off, and (P+1) * 2^TICK_W * 2^(T+1) clocks apart with it on.
- R8: Writing 1 to status bit 8+n clears it, and writing 0 leaves it unchanged.
- R9: When a new result for channel n arrives in the same cycle as a write that clears status bit 8+n, the bit stays set.
- R10: `irq` equals the OR over n of (status bit 8+n AND interrupt enable bit 8+n). With the enables clear, `irq` stays low even while flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| sns_req | output | 1 | Sample request to the converter |
| sns_chan | output | CW | Channel being sampled |
| sns_acq0 | output | ACQ_W | First acquisition time |
| sns_acq1 | output | ACQ_W | Second acquisition time |
| sns_valid | input | 1 | Converter sample valid |
| sns_data | input | DW | Raw converter sample |
| irq | output | 1 | Data-ready interrupt, registered |

## Verification
The main function is swept over enable masks (all channels, alternating pairs, single edge channels), both filter settings, every filter type and two period values. Each result is compared with a mean the bench computes from the exact samples it fed in. Exact means across every type separate a wrong shift or group count from a correct one, and the measured spacing between interrupts separates period and filter-depth scaling errors. Mixed masks expose a sequencer that skips, repeats or reorders channels, or touches a disabled one. Directed steps cover flag clearing with zero and one bits, a clear that collides with a fresh result, and interrupt masking.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam int OFF_CTRL0 = 'h00;
  localparam int OFF_CTRL2 = 'h40;
  localparam int OFF_INTC  = 'h44;
  localparam int OFF_STAT  = 'h48;
  localparam int OFF_FILT  = 'h70;
  localparam int OFF_CAL   = 'h74;
  localparam int OFF_DATA0 = 'h80;
  localparam logic [31:0] CAL_RST = 32'h0800_0800;
  localparam int TYPE_W = 2;
endpackage

// File: rtl/thm_timer.sv
module thm_timer #(
  parameter int TICK_W = 12,
  parameter int PER_W  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PER_W-1:0] per,
  output logic             tick
);
  logic [TICK_W-1:0] sub;
  logic [PER_W-1:0]  pcnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sub  <= '0;
      pcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      sub  <= sub + 1'b1;
      if (&sub) begin
        if (pcnt >= per) begin
          pcnt <= '0;
          tick <= 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/thm_seq.sv
module thm_seq #(
  parameter int NCH = 4,
  parameter int DW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [NCH-1:0] en,
  output logic           req,
  output logic [CW-1:0]  chan,
  input  logic           sns_valid,
  input  logic [DW-1:0]  sns_data,
  output logic [NCH-1:0] smp_v,
  output logic [DW-1:0]  smp_d
);
  logic [NCH-1:0] pend, pend_n, live;
  logic [CW-1:0]  pick;
  logic           any;

  assign live  = pend & en;
  assign smp_d = sns_data;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (live[i]) begin
        pick = CW'(i);
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    pend_n = live;
    if (req && sns_valid) pend_n[chan] = 1'b0;
    if (tick) pend_n = pend_n | en;
  end

  always_comb begin
    smp_v = '0;
    if (req && sns_valid) smp_v[chan] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      req  <= 1'b0;
      chan <= '0;
    end else begin
      pend <= pend_n;
      if (req) begin
        if (sns_valid) req <= 1'b0;
      end else if (any) begin
        req  <= 1'b1;
        chan <= pick;
      end
    end
  end
endmodule

// File: rtl/thm_avg.sv
module thm_avg
  import thm_pkg::*;
#(
  parameter int DW = 12,
  localparam int CNT_W = 1 << TYPE_W,
  localparam int ACC_W = DW + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              smp_v,
  input  logic [DW-1:0]     smp_d,
  input  logic              f_en,
  input  logic [TYPE_W-1:0] f_type,
  output logic              res_v,
  output logic [DW-1:0]     res_d
);
  logic [ACC_W-1:0] acc, sum;
  logic [CNT_W-1:0] cnt, gmask;
  logic [TYPE_W:0]  sh;

  assign sum   = acc + ACC_W'(smp_d);
  assign sh    = {1'b0, f_type} + 1'b1;
  assign gmask = CNT_W'((32'd2 << f_type) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc   <= '0;
      cnt   <= '0;
      res_v <= 1'b0;
      if (rst) res_d <= '0;
    end else begin
      res_v <= 1'b0;
      if (smp_v) begin
        if (!f_en) begin
          res_v <= 1'b1;
          res_d <= smp_d;
        end else if (cnt == gmask) begin
          res_v <= 1'b1;
          res_d <= DW'(sum >> sh);
          acc   <= '0;
          cnt   <= '0;
        end else begin
          acc <= sum;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/thm_regs.sv
module thm_regs
  import thm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DW    = 12,
  parameter int PER_W = 20,
  parameter int ACQ_W = 16,
  parameter int AW    = 8,
  localparam int CW   = $clog2(NCH),
  localparam int WA_W = AW - 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [NCH-1:0]          res_v,
  input  logic [NCH-1:0][DW-1:0]  res_d,
  output logic [NCH-1:0]          en,
  output logic [PER_W-1:0]        per,
  output logic                    f_en,
  output logic [TYPE_W-1:0]       f_type,
  output logic                    f_wr,
  output logic [ACQ_W-1:0]        acq0,
  output logic [ACQ_W-1:0]        acq1,
  output logic [NCH-1:0]          stat,
  output logic [NCH-1:0]          ie,
  output logic                    irq
);
  localparam logic [WA_W-1:0] W_CTRL0 = WA_W'(OFF_CTRL0 >> 2);
  localparam logic [WA_W-1:0] W_CTRL2 = WA_W'(OFF_CTRL2 >> 2);
  localparam logic [WA_W-1:0] W_INTC  = WA_W'(OFF_INTC >> 2);
  localparam logic [WA_W-1:0] W_STAT  = WA_W'(OFF_STAT >> 2);
  localparam logic [WA_W-1:0] W_FILT  = WA_W'(OFF_FILT >> 2);
  localparam logic [WA_W-1:0] W_CAL   = WA_W'(OFF_CAL >> 2);
  localparam logic [WA_W-1:0] W_DATA0 = WA_W'(OFF_DATA0 >> 2);

  logic [WA_W-1:0] wa, doff;
  logic            dhit;
  logic [31:0]     cal, rmux;
  logic [NCH-1:0]  clr, stat_d, ie_d;
  logic [DW-1:0]   dat [NCH];
  logic            unused_lsb;

  assign wa         = addr[AW-1:2];
  assign unused_lsb = ^addr[1:0];
  assign doff       = wa - W_DATA0;
  assign dhit       = (wa >= W_DATA0) && (doff < WA_W'(NCH));
  assign f_wr       = wr && (wa == W_FILT);
  assign clr        = (wr && wa == W_STAT) ? wdata[8 +: NCH] : '0;
  assign stat_d     = (stat & ~clr) | res_v;
  assign ie_d       = (wr && wa == W_INTC) ? wdata[8 +: NCH] : ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      acq0 <= '0; acq1 <= '0; en <= '0; ie <= '0; per <= '0;
      f_en <= 1'b0; f_type <= '0; cal <= CAL_RST;
      stat <= '0; irq <= 1'b0;
      for (int i = 0; i < NCH; i++) dat[i] <= '0;
    end else begin
      if (wr) begin
        case (wa)
          W_CTRL0: acq0 <= wdata[ACQ_W-1:0];
          W_CTRL2: begin en <= wdata[NCH-1:0]; acq1 <= wdata[16 +: ACQ_W]; end
          W_INTC:  begin ie <= wdata[8 +: NCH]; per <= wdata[12 +: PER_W]; end
          W_FILT:  begin f_en <= wdata[2]; f_type <= wdata[TYPE_W-1:0]; end
          W_CAL:   cal <= wdata;
          default: ;
        endcase
      end
      stat <= stat_d;
      irq  <= |(stat_d & ie_d);
      for (int i = 0; i < NCH; i++)
        if (res_v[i]) dat[i] <= res_d[i];
    end
  end

  always_comb begin
    rmux = '0;
    case (wa)
      W_CTRL0: rmux[ACQ_W-1:0] = acq0;
      W_CTRL2: begin rmux[NCH-1:0] = en; rmux[16 +: ACQ_W] = acq1; end
      W_INTC:  begin rmux[8 +: NCH] = ie; rmux[12 +: PER_W] = per; end
      W_STAT:  rmux[8 +: NCH] = stat;
      W_FILT:  rmux[2:0] = {f_en, f_type};
      W_CAL:   rmux = cal;
      default: if (dhit) rmux[DW-1:0] = dat[doff[CW-1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= rmux;
  end
endmodule

// File: rtl/thm_sample_ctrl.sv
module thm_sample_ctrl
  import thm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DW     = 12,
  parameter int TICK_W = 12,
  parameter int PER_W  = 20,
  parameter int ACQ_W  = 16,
  parameter int AW     = 8,
  localparam int CW    = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             sns_req,
  output logic [CW-1:0]    sns_chan,
  output logic [ACQ_W-1:0] sns_acq0,
  output logic [ACQ_W-1:0] sns_acq1,
  input  logic             sns_valid,
  input  logic [DW-1:0]    sns_data,
  output logic             irq
);
  logic [NCH-1:0]          ch_en, stat, ie, smp_v, res_v;
  logic [NCH-1:0][DW-1:0]  res_d;
  logic [PER_W-1:0]        per;
  logic                    f_en, f_wr, tick;
  logic [TYPE_W-1:0]       f_type;
  logic [DW-1:0]           smp_d;

  thm_regs #(.NCH(NCH), .DW(DW), .PER_W(PER_W), .ACQ_W(ACQ_W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .res_v(res_v), .res_d(res_d),
    .en(ch_en), .per(per), .f_en(f_en), .f_type(f_type), .f_wr(f_wr),
    .acq0(sns_acq0), .acq1(sns_acq1), .stat(stat), .ie(ie), .irq(irq)
  );

  thm_timer #(.TICK_W(TICK_W), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .run(|ch_en), .per(per), .tick(tick)
  );

  thm_seq #(.NCH(NCH), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .en(ch_en), .req(sns_req),
    .chan(sns_chan), .sns_valid(sns_valid), .sns_data(sns_data),
    .smp_v(smp_v), .smp_d(smp_d)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_avg
    thm_avg #(.DW(DW)) u_avg (
      .clk(clk), .rst(rst), .clr(f_wr), .smp_v(smp_v[g]), .smp_d(smp_d),
      .f_en(f_en), .f_type(f_type), .res_v(res_v[g]), .res_d(res_d[g])
    );
  end
endmodule

// File: rtl/thm_sample_chk.sv
module thm_sample_chk
  import thm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 2,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           sns_req,
  input logic [CW-1:0]  sns_chan,
  input logic           sns_valid,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] res_v,
  input logic [NCH-1:0] stat,
  input logic [NCH-1:0] ie,
  input logic           irq,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata
);
  logic [NCH-1:0] wclr;
  logic           stat_wr;
  assign wclr    = bus_wdata[8 +: NCH];
  assign stat_wr = bus_wr && (bus_addr[AW-1:2] == (AW-2)'(OFF_STAT >> 2));

  assert_req_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sns_req) |-> ((($past(ch_en) >> sns_chan) & 1) != 0));
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (ch_en == '0) && !sns_req |=> !sns_req);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    sns_req && !sns_valid |=> sns_req && $stable(sns_chan));
  assert_one_result_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(res_v));
  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    stat_wr && (res_v == '0) |=> (stat & $past(wclr)) == '0);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|res_v) |=> (stat & $past(res_v)) == $past(res_v));
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat & ie));
endmodule

bind thm_sample_ctrl thm_sample_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .sns_req(sns_req), .sns_chan(sns_chan),
  .sns_valid(sns_valid), .ch_en(ch_en), .res_v(res_v), .stat(stat),
  .ie(ie), .irq(irq), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata)
);

// File: tb/sim_thm_sample_ctrl.sv
module sim_thm_sample_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW = 12;
  localparam int TICK_W = 4;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sns_req, sns_valid, irq;
  logic [1:0] sns_chan;
  logic [15:0] sns_acq0, sns_acq1;
  logic [DW-1:0] sns_data;

  int total = 0, bad = 0, cyc = 0;
  int bad_dis = 0, bad_ord = 0;
  int gsz = 1, last_chan = NCH - 1;
  int gsum [NCH], gcnt [NCH], expv [NCH], kc [NCH];
  logic [NCH-1:0] cur_en = '0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  thm_sample_ctrl #(.NCH(NCH), .DW(DW), .TICK_W(TICK_W)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sns_req(sns_req), .sns_chan(sns_chan), .sns_acq0(sns_acq0),
    .sns_acq1(sns_acq1), .sns_valid(sns_valid), .sns_data(sns_data),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expd);
    total++;
    if (act !== expd) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expd);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int next_chan(input int last, input logic [NCH-1:0] en);
    for (int i = 1; i <= NCH; i++)
      if (en[(last + i) % NCH]) return (last + i) % NCH;
    return -1;
  endfunction

  // Converter model: answers each request LAT cycles later and keeps the expected averages.
  initial begin
    int c, d;
    sns_valid = 1'b0;
    sns_data = '0;
    for (int i = 0; i < NCH; i++) begin gsum[i] = 0; gcnt[i] = 0; expv[i] = 0; kc[i] = 0; end
    forever begin
      @(negedge clk);
      if (!rst && sns_req && !sns_valid) begin
        c = int'(sns_chan);
        if (!cur_en[c]) bad_dis++;
        if (c != next_chan(last_chan, cur_en)) bad_ord++;
        last_chan = c;
        repeat (LAT - 1) @(negedge clk);
        d = (c * 'h351 + kc[c] * 'h1F7 + 'h123) % 4096;
        kc[c]++;
        sns_data = DW'(d);
        sns_valid = 1'b1;
        gsum[c] += d;
        gcnt[c]++;
        if (gcnt[c] == gsz) begin
          expv[c] = gsum[c] / gsz;
          gsum[c] = 0;
          gcnt[c] = 0;
        end
        @(negedge clk);
        sns_valid = 1'b0;
      end
    end
  end

  task automatic setup(input logic [NCH-1:0] mask, input int p, input bit fen, input int t);
    int hi = 0;
    bwrite(8'h40, 32'h0);
    repeat (40) @(negedge clk);
    cur_en = '0;
    bwrite(8'h70, {29'd0, fen, 2'(t)});
    gsz = fen ? (2 << t) : 1;
    last_chan = NCH - 1;
    for (int i = 0; i < NCH; i++) begin
      gsum[i] = 0; gcnt[i] = 0;
      if (mask[i]) hi = i;
    end
    bwrite(8'h44, (32'(p) << 12) | (32'h1 << (8 + hi)));
    bwrite(8'h48, 32'hF00);
    cur_en = mask;
    bwrite(8'h40, {16'h003F, 12'd0, mask});
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    while (!irq && n < 8000) begin @(negedge clk); n++; end
    if (!irq) chk("R7 interrupt timeout", 0, 1);
    t = cyc;
  endtask

  task automatic run_cfg(input logic [NCH-1:0] mask, input int p, input bit fen, input int t);
    int tnow, tprev = 0, per;
    logic [31:0] r;
    setup(mask, p, fen, t);
    per = (p + 1) * (1 << TICK_W) * (fen ? (2 << t) : 1);
    for (int k = 0; k < 3; k++) begin
      wait_irq(tnow);
      bread(8'h48, r);
      chk(fen ? "R6 status" : "R5 status", r, {20'd0, mask, 8'd0});
      for (int c = 0; c < NCH; c++) begin
        if (mask[c]) begin
          bread(8'(8'h80 + 4 * c), r);
          chk(fen ? "R6 average" : "R5 raw sample", r, 32'(expv[c]));
        end
      end
      bwrite(8'h48, 32'hF00);
      @(negedge clk);
      chk("R8 clear drops irq", {31'd0, irq}, 0);
      if (k > 0) chk("R7 result spacing", 32'(tnow - tprev), 32'(per));
      tprev = tnow;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk("watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int hi_cnt, t;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 sns_req", {31'd0, sns_req}, 0);
    bread(8'h00, r); chk("R1 ctrl0", r, 0);
    bread(8'h40, r); chk("R1 ctrl2", r, 0);
    bread(8'h44, r); chk("R1 intc", r, 0);
    bread(8'h48, r); chk("R1 status", r, 0);
    bread(8'h70, r); chk("R1 filter", r, 0);
    bread(8'h74, r); chk("R1 calibration", r, 32'h0800_0800);
    for (int c = 0; c < NCH; c++) begin
      bread(8'(8'h80 + 4 * c), r); chk("R1 data", r, 0);
    end
    // R2 read-back masks
    bwrite(8'h00, 32'hFFFF_FFFF); bread(8'h00, r); chk("R2 ctrl0", r, 32'h0000_FFFF);
    bwrite(8'h70, 32'hFFFF_FFFF); bread(8'h70, r); chk("R2 filter", r, 32'h7);
    bwrite(8'h74, 32'h0123_07A5); bread(8'h74, r); chk("R2 calibration", r, 32'h0123_07A5);
    bwrite(8'h44, 32'hFFFF_FFFF); bread(8'h44, r); chk("R2 intc", r, 32'hFFFF_FF00);
    bwrite(8'h40, 32'hFFFF_FFFF); bread(8'h40, r); chk("R2 ctrl2", r, 32'hFFFF_000F);
    bwrite(8'h40, 32'h0);
    bwrite(8'h44, 32'h0);
    bwrite(8'h04, 32'hFFFF_FFFF); bread(8'h04, r); chk("R2 unmapped", r, 0);
    bread(8'h48, r); chk("R3 no samples while period far away", r, 0);

    // main sweep
    run_cfg(4'hF, 1, 1'b0, 0);
    run_cfg(4'h5, 3, 1'b0, 0);
    run_cfg(4'hA, 1, 1'b0, 0);
    for (int t2 = 0; t2 < 4; t2++) begin
      run_cfg(4'hF, 1, 1'b1, t2);
      run_cfg(t2[0] ? 4'h9 : 4'h6, 2, 1'b1, t2);
    end
    run_cfg(4'h8, 0, 1'b1, 1);
    run_cfg(4'h1, 1, 1'b0, 0);

    // R10 gating
    setup(4'h1, 3, 1'b0, 0);
    bwrite(8'h44, 32'(3) << 12);
    hi_cnt = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (irq) hi_cnt++; end
    chk("R10 irq masked", 32'(hi_cnt), 0);
    bread(8'h48, r); chk("R10 flag set while masked", r, 32'h100);
    bwrite(8'h44, (32'(3) << 12) | 32'h100);
    chk("R10 irq after enable", {31'd0, irq}, 1);

    // R8 write zero and write one
    bwrite(8'h48, 32'hF00);
    wait_irq(t);
    bwrite(8'h48, 32'h0); bread(8'h48, r); chk("R8 write zero keeps", r, 32'h100);
    bwrite(8'h48, 32'h100); bread(8'h48, r); chk("R8 write one clears", r, 0);

    // R9 collision of clear and new result
    @(posedge sns_valid);
    bwrite(8'h48, 32'h100);
    bread(8'h48, r); chk("R9 set wins over clear", r, 32'h100);

    bwrite(8'h40, 32'h0);
    repeat (40) @(negedge clk);
    chk("R3 disabled channel requested", 32'(bad_dis), 0);
    chk("R4 request order", 32'(bad_ord), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule